// File: doc/BRIEF.md
# Interrupt Concentrator and Dispatcher

This block gathers level-sensitive interrupt requests and issues them one at a time as interrupt packets on a valid/ready output port. It has two sources of requests. The first is two PCI bus segments, each with four shared lines. The second is a parameterised group of internal bridge sources. Each source maps to a fixed 6-bit interrupt number, and that number travels in the packet together with a 2-bit tag naming where the request came from.

A PCI interrupt can signal that a DMA transfer has finished. The packet must therefore not overtake write data from that same segment that is still posted in its bus module. Before a PCI-originated packet goes out, the block raises a flush request toward the originating segment. It then waits until the bus module reports that its posted consistent DMA writes have drained. Internal sources use the same path and skip this step.

Each source moves through four states: idle, pending, flush-wait and sent. A sent source stays quiet until software writes a clear carrying its interrupt number.

Top module: `intr_dispatch`

## Requirements
- R1: After reset, `pkt_valid` is low and `flush_req` is zero.
- R2: Interrupt numbers are assigned as follows. Segment s, line l (A=0, B=1, C=2, D=3) maps to s*16+l. Internal source i maps to 0x20+i. `pkt_tag` is 0 for segment 0, 1 for segment 1 and 2 for internal sources.
- R3: With no flush wait, `pkt_valid` rises six clock edges after the first edge that samples a request high while the block is otherwise idle.
- R4: For a PCI source, `flush_req` is raised only for the originating segment (bit s), and it stays high until `flush_done[s]` is sampled high. Each edge at which `flush_done[s]` is low while the request is up delays the packet by one cycle. `flush_req` is low whenever a packet is presented.
- R5: Internal sources never raise `flush_req`.
- R6: When several sources are pending, the lowest interrupt number is dispatched first.
- R7: Only one packet is outstanding at a time. While `pkt_valid` is high and `pkt_ready` is low, `pkt_valid`, `pkt_num` and `pkt_tag` hold their values.
- R8: A sent source is not dispatched again until a clear (`clr_valid` with `clr_num` equal to its number) is seen. A clear naming a source that is not in the sent state, or naming an unused number, has no effect.
- R9: A request is latched when first sampled. A line that is high for a single cycle is still dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg0_irq | input | 4 | Segment 0 shared lines A..D (bit 0 = A) |
| seg1_irq | input | 4 | Segment 1 shared lines A..D (bit 0 = A) |
| int_irq | input | NUM_INT | Internal bridge interrupt sources |
| flush_req | output | 2 | Ask segment s to drain posted consistent DMA writes |
| flush_done | input | 2 | Segment s reports its posted writes sent upstream |
| pkt_valid | output | 1 | Interrupt packet presented |
| pkt_ready | input | 1 | Packet accepted by the system side |
| pkt_num | output | 6 | Interrupt number in the packet |
| pkt_tag | output | 2 | Source tag: 0 seg0, 1 seg1, 2 internal |
| clr_valid | input | 1 | Software clear strobe |
| clr_num | input | 6 | Interrupt number being cleared |

## Verification
Two functions can fall in the same cycle. The first is the handshake that retires one packet. The second is the arbitration for the next packet, which chooses among sources whose lines are still high. The bench raises three lines from different groups at once and holds them high. It releases the packets one after another and checks that the scoreboard sees them in ascending number order with no duplicates. It then confirms that no further packet appears while the lines stay high, until the matching clear is written. The flush handshake is tested by holding the segment's drained indication low for a known number of cycles and checking that the delay matches.

// File: rtl/intr_dispatch.sv
module intr_dispatch #(
  parameter int NUM_INT = 4,
  parameter int LAT     = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [3:0]         seg0_irq,
  input  logic [3:0]         seg1_irq,
  input  logic [NUM_INT-1:0] int_irq,
  output logic [1:0]         flush_req,
  input  logic [1:0]         flush_done,
  output logic               pkt_valid,
  input  logic               pkt_ready,
  output logic [5:0]         pkt_num,
  output logic [1:0]         pkt_tag,
  input  logic               clr_valid,
  input  logic [5:0]         clr_num
);

  localparam int NSRC = 8 + NUM_INT;
  localparam int IW   = $clog2(NSRC);
  localparam int CW   = $clog2(LAT);
  localparam logic [1:0] S_IDLE = 2'd0, S_PEND = 2'd1, S_FWAIT = 2'd2, S_SENT = 2'd3;

  function automatic logic [5:0] num_of(input int i);
    if (i < 4)      return 6'(i);
    else if (i < 8) return 6'(16 + i - 4);
    else            return 6'(32 + i - 8);
  endfunction

  logic [NSRC-1:0]       raw;
  logic [NSRC-1:0][1:0]  st;
  logic                  pick_vld;
  logic [IW-1:0]         pick_idx;
  logic                  busy, flushed;
  logic [IW-1:0]         cur;
  logic [CW-1:0]         cnt;
  logic                  cur_pci, cur_seg, ack_ok, adv, hs;

  assign raw     = {int_irq, seg1_irq, seg0_irq};
  assign cur_pci = (cur < IW'(8));
  assign cur_seg = cur[2];
  assign ack_ok  = flushed || flush_done[cur_seg];
  assign adv     = busy && (cnt != CW'(LAT-1)) && (!cur_pci || ack_ok);
  assign pkt_valid = busy && (cnt == CW'(LAT-1));
  assign hs      = pkt_valid && pkt_ready;
  assign pkt_num = num_of(int'(cur));
  assign pkt_tag = cur_pci ? {1'b0, cur_seg} : 2'd2;

  always_comb begin
    flush_req = 2'b00;
    if (busy && cur_pci && !flushed) flush_req[cur_seg] = 1'b1;
  end

  always_comb begin
    pick_vld = 1'b0;
    pick_idx = '0;
    for (int i = NSRC-1; i >= 0; i--)
      if (st[i] == S_PEND) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      flushed <= 1'b0;
      cur     <= '0;
      cnt     <= '0;
    end else if (!busy) begin
      if (pick_vld) begin
        busy    <= 1'b1;
        cur     <= pick_idx;
        cnt     <= '0;
        flushed <= 1'b0;
      end
    end else begin
      if (hs) busy <= 1'b0;
      if (adv) cnt <= cnt + 1'b1;
      if (|flush_req && flush_done[cur_seg]) flushed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      for (int i = 0; i < NSRC; i++) begin
        case (st[i])
          S_IDLE:  if (raw[i]) st[i] <= S_PEND;
          S_PEND:  if (!busy && pick_vld && pick_idx == IW'(i)) st[i] <= S_FWAIT;
          S_FWAIT: if (hs && cur == IW'(i)) st[i] <= S_SENT;
          default: if (clr_valid && clr_num == num_of(i)) st[i] <= S_IDLE;
        endcase
      end
    end
  end

  logic [1:0] ack_seen;
  always_ff @(posedge clk) begin
    if (!rst_n) ack_seen <= 2'b00;
    else if (hs) ack_seen <= 2'b00;
    else ack_seen <= ack_seen | (flush_req & flush_done);
  end

  AST_FLUSH_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(flush_req)); // R4
  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_num) && $stable(pkt_tag)); // R7
  AST_PCI_AFTER_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_tag[1] |-> ack_seen[pkt_tag[0]] && flush_req == 2'b00); // R4
  AST_INT_NO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_tag[1] |-> ack_seen == 2'b00); // R5

endmodule

// File: tb/intr_dispatch_tb.sv
module intr_dispatch_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] seg0_irq = 0, seg1_irq = 0;
  logic [3:0] int_irq = 0;
  logic [1:0] flush_req, flush_done = 2'b11;
  logic pkt_valid, pkt_ready = 0;
  logic [5:0] pkt_num;
  logic [1:0] pkt_tag;
  logic clr_valid = 0;
  logic [5:0] clr_num = 0;
  int checks = 0, errors = 0;
  logic [5:0] exp_q[$];
  logic [5:0] held;

  always #2 clk = ~clk;

  intr_dispatch dut_i (.clk(clk), .rst_n(rst_n), .seg0_irq(seg0_irq), .seg1_irq(seg1_irq),
    .int_irq(int_irq), .flush_req(flush_req), .flush_done(flush_done), .pkt_valid(pkt_valid),
    .pkt_ready(pkt_ready), .pkt_num(pkt_num), .pkt_tag(pkt_tag), .clr_valid(clr_valid),
    .clr_num(clr_num));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic accept();
    @(negedge clk); pkt_ready = 1;
    @(negedge clk); pkt_ready = 0;
  endtask

  task automatic clear(input logic [5:0] n);
    @(negedge clk); clr_valid = 1; clr_num = n;
    @(negedge clk); clr_valid = 0;
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: R2 numbering/tag, R6 order
  always @(negedge clk) begin
    #1;
    if (rst_n && pkt_valid && pkt_ready) begin
      if (exp_q.size() == 0) chk("R8 unexpected packet", pkt_num, 6'h3f);
      else begin
        logic [5:0] e;
        e = exp_q.pop_front();
        chk("R2 R6 number", pkt_num, e);
        chk("R2 tag", pkt_tag, e[5] ? 2 : e[4]);
      end
    end
  end

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitc(3);
    rst_n = 1;
    @(negedge clk);
    chk("R1 valid", pkt_valid, 0);
    chk("R1 flush", flush_req, 0);

    // R3 latency, R5 no flush for internal
    @(negedge clk); int_irq[1] = 1; exp_q.push_back(6'h21);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R5 flush_req", flush_req, 0);
    end
    chk("R3 early", pkt_valid, 0);
    @(negedge clk);
    chk("R3 on time", pkt_valid, 1);
    accept(); int_irq[1] = 0; clear(6'h21);

    // R9 one-cycle pulse
    @(negedge clk); seg0_irq[1] = 1; exp_q.push_back(6'h01);
    @(negedge clk); seg0_irq[1] = 0;
    waitc(8);
    chk("R9 latched", pkt_valid, 1);
    accept(); clear(6'h01);

    // R6 priority, R7 hold
    @(negedge clk); seg1_irq[0] = 1; int_irq[0] = 1; seg0_irq[3] = 1;
    exp_q.push_back(6'h03); exp_q.push_back(6'h10); exp_q.push_back(6'h20);
    waitc(8);
    chk("R7 valid", pkt_valid, 1);
    held = pkt_num;
    chk("R6 first", pkt_num, 6'h03);
    waitc(3);
    chk("R7 held valid", pkt_valid, 1);
    chk("R7 held num", pkt_num, held);
    accept(); waitc(8); accept(); waitc(8); accept();

    // R8 no resend, ignored clears
    waitc(12);
    chk("R8 no resend", pkt_valid, 0);
    clear(6'h05); clear(6'h11);
    waitc(10);
    chk("R8 bad clear ignored", pkt_valid, 0);
    clear(6'h10); exp_q.push_back(6'h10);
    waitc(8);
    chk("R8 resend after clear", pkt_valid, 1);
    accept();
    seg1_irq = 0; int_irq = 0; seg0_irq = 0;
    clear(6'h03); clear(6'h10); clear(6'h20);

    // R4 flush wait
    @(negedge clk); flush_done = 2'b01; seg1_irq[2] = 1; exp_q.push_back(6'h12);
    waitc(2);
    chk("R4 flush_req seg1", flush_req, 2'b10);
    waitc(3); flush_done = 2'b11;
    waitc(4);
    chk("R4 delayed", pkt_valid, 0);
    @(negedge clk);
    chk("R4 after flush", pkt_valid, 1);
    chk("R4 req dropped", flush_req, 0);
    accept(); seg1_irq[2] = 0; clear(6'h12);

    // R2 mapping
    @(negedge clk); seg1_irq[3] = 1; int_irq[3] = 1; seg0_irq[0] = 1;
    exp_q.push_back(6'h00); exp_q.push_back(6'h13); exp_q.push_back(6'h23);
    waitc(8); accept(); waitc(8); accept(); waitc(8); accept();
    seg1_irq = 0; int_irq = 0; seg0_irq = 0;
    clear(6'h00); clear(6'h13); clear(6'h23);
    waitc(4);
    chk("R2 R6 queue drained", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule